// File: doc/BRIEF.md
# Addressed Link Block Receiver

This block sits behind a byte deserializer once the card has finished its answer-to-reset, and turns the byte stream into link-layer blocks. It hunts for an address byte, then takes a control byte, a length byte, that many payload bytes and a closing check byte. It stores the payload in a local buffer, checks that the XOR of every byte of the block is zero, and decodes the control byte into a block kind with its sequence numbers.

A good block raises a one-cycle valid strobe and presents the source and destination nibbles, the kind, the send and receive sequence numbers and the length. A failed check raises a one-cycle error strobe instead. The payload can be read at any time through a combinational read port. When the serial link reports a character timeout, the receiver drops any partial block and goes back to hunting. When the inverse convention is selected, every incoming byte is bit-reversed before it is used.

Top module: `blk_frame_rx`

## Requirements
- R1: While hunting, a byte is taken as an address only if its high nibble or its low nibble equals 1. Any other byte is dropped and the receiver keeps hunting, so a correct block that follows is still received.
- R2: On a good block, `frm_src` shows the address bits 7:4 and `frm_dst` shows the address bits 3:0.
- R3: After the address come a control byte, a length byte, exactly that many payload bytes and one check byte. On a good block, `frm_len` equals the length byte and `rd_data` at `rd_addr` = i shows payload byte i.
- R4: If the XOR of address, control, length, payload and check bytes is zero, `frm_valid` is high for exactly one cycle, in the cycle after the edge that takes the check byte, and `chk_err` stays low.
- R5: If that XOR is not zero, `chk_err` is high for exactly one cycle at the same point, `frm_valid` stays low, and all frame fields keep the values of the last good block.
- R6: A control byte with bits 4 and 0 both zero is an information block: `frm_type` = 0, `frm_ns` = bits 3:1, `frm_nr` = bits 7:5.
- R7: A control byte whose bits 4:0 equal 5'b01001 is a reject block: `frm_type` = 1, `frm_nr` = bits 7:5, `frm_ns` = 0.
- R8: The control byte 8'hEF is a reset block, `frm_type` = 2; any control byte matching none of the three codes gives `frm_type` = 3. For both, `frm_ns` and `frm_nr` are 0.
- R9: With `inv_order` high, each received byte is bit-reversed (bit 7 becomes bit 0) before any other use, including the address test and the XOR.
- R10: A `timeout` pulse in any state other than hunting discards the partial block and returns to hunting, so the next byte is tested as an address.
- R11: A length byte of 0 moves straight to the check byte; the fourth byte of the block is its check byte.
- R12: After reset, `frm_valid` and `chk_err` are low and all frame fields are zero.
- R13: Frame fields hold until the next good block, and the payload buffer keeps its contents until a new address byte is accepted; dropped non-address bytes leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A received byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Received byte as delivered by the deserializer |
| inv_order | input | 1 | Bit-reverse each byte before use |
| timeout | input | 1 | Character timeout from the serial link |
| rd_addr | input | 8 | Payload buffer read index |
| rd_data | output | 8 | Payload byte at `rd_addr` (combinational) |
| frm_valid | output | 1 | One-cycle strobe for a good block |
| chk_err | output | 1 | One-cycle strobe for a block with a bad check |
| frm_src | output | 4 | Source nibble of the last good block |
| frm_dst | output | 4 | Destination nibble of the last good block |
| frm_type | output | 2 | Block kind: 0 info, 1 reject, 2 reset, 3 unknown |
| frm_ns | output | 3 | Send sequence number |
| frm_nr | output | 3 | Receive sequence number |
| frm_len | output | 8 | Payload length of the last good block |

## Verification
Each byte is presented for one cycle from a falling edge and taken at the next rising edge; the strobes and the frame fields are registered at the edge that takes the check byte, so they are due one cycle later and the bench samples them at the falling edge right after that byte, then again one falling edge later to see the strobe gone. The payload read port has no register, so the bench changes `rd_addr` and compares `rd_data` a fraction of a cycle later within the same cycle. Hold behaviour after errors, dropped bytes and timeouts is checked at the falling edge that follows the last stimulus byte, before any further block is sent.

// File: rtl/blkrx_pkg.sv
package blkrx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_CTRL  = 3'd1,
    ST_LEN   = 3'd2,
    ST_BODY  = 3'd3,
    ST_CHECK = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    FK_INFO   = 2'd0,
    FK_REJECT = 2'd1,
    FK_RESET  = 2'd2,
    FK_OTHER  = 2'd3
  } frm_kind_e;

  localparam logic [BYTE_W-1:0] RESET_CODE = 8'hEF;

endpackage

// File: rtl/blkrx_bit_order.sv
module blkrx_bit_order #(
  parameter int unsigned W = 8
) (
  input  logic         inv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q[i] = inv ? d[W-1-i] : d[i];
  end
endmodule

// File: rtl/blkrx_ctrl_decode.sv
module blkrx_ctrl_decode
  import blkrx_pkg::*;
(
  input  logic [BYTE_W-1:0] ctrl,
  output logic [1:0]        kind,
  output logic [2:0]        ns,
  output logic [2:0]        nr
);
  always_comb begin
    kind = FK_OTHER;
    ns   = 3'd0;
    nr   = 3'd0;
    if ((ctrl & 8'h11) == 8'h00) begin
      kind = FK_INFO;
      ns   = ctrl[3:1];
      nr   = ctrl[7:5];
    end else if ((ctrl & 8'h1F) == 8'h09) begin
      kind = FK_REJECT;
      nr   = ctrl[7:5];
    end else if (ctrl == RESET_CODE) begin
      kind = FK_RESET;
    end
  end
endmodule

// File: rtl/blkrx_payload_buf.sv
module blkrx_payload_buf #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/blkrx_frame_fsm.sv
module blkrx_frame_fsm
  import blkrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_d,
  input  logic              timeout,
  output rx_state_e         state,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frm_valid,
  output logic              chk_err,
  output logic [NIB_W-1:0]  frm_src,
  output logic [NIB_W-1:0]  frm_dst,
  output logic [1:0]        frm_type,
  output logic [2:0]        frm_ns,
  output logic [2:0]        frm_nr,
  output logic [BYTE_W-1:0] frm_len
);
  localparam logic [NIB_W-1:0]  NIB_ONE  = NIB_W'(1);
  localparam logic [BYTE_W-1:0] LEN_ONE  = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] LEN_ZERO = '0;

  rx_state_e         st_q, st_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] len_q, len_d;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0] xor_q, xor_d;
  logic              done_ok, done_bad;
  logic              step_en;
  logic              addr_ok;

  logic [1:0] dec_kind;
  logic [2:0] dec_ns, dec_nr;

  blkrx_ctrl_decode u_dec (
    .ctrl (ctrl_q),
    .kind (dec_kind),
    .ns   (dec_ns),
    .nr   (dec_nr)
  );

  assign addr_ok = (byte_d[BYTE_W-1:NIB_W] == NIB_ONE) || (byte_d[NIB_W-1:0] == NIB_ONE);
  assign step_en = byte_vld | timeout;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    ctrl_d   = ctrl_q;
    len_d    = len_q;
    cnt_d    = cnt_q;
    xor_d    = xor_q;
    wr_en    = 1'b0;
    done_ok  = 1'b0;
    done_bad = 1'b0;
    if (timeout) begin
      st_d = ST_HUNT;
    end else if (byte_vld) begin
      case (st_q)
        ST_HUNT: begin
          if (addr_ok) begin
            st_d   = ST_CTRL;
            addr_d = byte_d;
            xor_d  = byte_d;
          end
        end
        ST_CTRL: begin
          ctrl_d = byte_d;
          xor_d  = xor_q ^ byte_d;
          st_d   = ST_LEN;
        end
        ST_LEN: begin
          len_d = byte_d;
          cnt_d = '0;
          xor_d = xor_q ^ byte_d;
          st_d  = (byte_d == LEN_ZERO) ? ST_CHECK : ST_BODY;
        end
        ST_BODY: begin
          wr_en = 1'b1;
          cnt_d = cnt_q + LEN_ONE;
          xor_d = xor_q ^ byte_d;
          if (cnt_q == len_q - LEN_ONE) begin
            st_d = ST_CHECK;
          end
        end
        ST_CHECK: begin
          st_d = ST_HUNT;
          if ((xor_q ^ byte_d) == '0) begin
            done_ok = 1'b1;
          end else begin
            done_bad = 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  assign wr_addr = cnt_q;
  assign wr_data = byte_d;
  assign state   = st_q;

  // parser registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      addr_q <= '0;
      ctrl_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      xor_q  <= '0;
    end else if (step_en) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      ctrl_q <= ctrl_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
      xor_q  <= xor_d;
    end
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      chk_err   <= 1'b0;
    end else begin
      frm_valid <= done_ok;
      chk_err   <= done_bad;
    end
  end

  // frame fields, loaded only on a good block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_src  <= '0;
      frm_dst  <= '0;
      frm_type <= '0;
      frm_ns   <= '0;
      frm_nr   <= '0;
      frm_len  <= '0;
    end else if (done_ok) begin
      frm_src  <= addr_q[BYTE_W-1:NIB_W];
      frm_dst  <= addr_q[NIB_W-1:0];
      frm_type <= dec_kind;
      frm_ns   <= dec_ns;
      frm_nr   <= dec_nr;
      frm_len  <= len_q;
    end
  end
endmodule

// File: rtl/blk_frame_rx.sv
module blk_frame_rx
  import blkrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       inv_order,
  input  logic       timeout,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       frm_valid,
  output logic       chk_err,
  output logic [3:0] frm_src,
  output logic [3:0] frm_dst,
  output logic [1:0] frm_type,
  output logic [2:0] frm_ns,
  output logic [2:0] frm_nr,
  output logic [7:0] frm_len
);
  logic [BYTE_W-1:0] byte_ord;
  rx_state_e         cur_state;
  logic              buf_we;
  logic [BYTE_W-1:0] buf_wa;
  logic [BYTE_W-1:0] buf_wd;

  blkrx_bit_order #(.W(BYTE_W)) u_ord (
    .inv (inv_order),
    .d   (byte_in),
    .q   (byte_ord)
  );

  blkrx_frame_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_valid),
    .byte_d    (byte_ord),
    .timeout   (timeout),
    .state     (cur_state),
    .wr_en     (buf_we),
    .wr_addr   (buf_wa),
    .wr_data   (buf_wd),
    .frm_valid (frm_valid),
    .chk_err   (chk_err),
    .frm_src   (frm_src),
    .frm_dst   (frm_dst),
    .frm_type  (frm_type),
    .frm_ns    (frm_ns),
    .frm_nr    (frm_nr),
    .frm_len   (frm_len)
  );

  blkrx_payload_buf #(.W(BYTE_W), .AW(BYTE_W)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (buf_wa),
    .wr_data (buf_wd),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/blk_frame_rx_chk.sv
module blk_frame_rx_chk
  import blkrx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       timeout,
  input rx_state_e  cur_state,
  input logic       frm_valid,
  input logic       chk_err,
  input logic [3:0] frm_src,
  input logic [3:0] frm_dst,
  input logic [1:0] frm_type,
  input logic [2:0] frm_ns,
  input logic [2:0] frm_nr,
  input logic [7:0] frm_len
);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && chk_err));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |=> !chk_err);

  p_addr_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_src == 4'd1 || frm_dst == 4'd1));

  p_fields_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |-> ($stable(frm_src) && $stable(frm_dst) && $stable(frm_type)
                    && $stable(frm_ns) && $stable(frm_nr) && $stable(frm_len)));

  p_err_keeps_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> $stable(frm_len));

  p_ns_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_type != FK_INFO) |-> frm_ns == 3'd0);

  p_nr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_type[1]) |-> frm_nr == 3'd0);

  p_timeout_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> cur_state == ST_HUNT);
endmodule

bind blk_frame_rx blk_frame_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .timeout   (timeout),
  .cur_state (cur_state),
  .frm_valid (frm_valid),
  .chk_err   (chk_err),
  .frm_src   (frm_src),
  .frm_dst   (frm_dst),
  .frm_type  (frm_type),
  .frm_ns    (frm_ns),
  .frm_nr    (frm_nr),
  .frm_len   (frm_len)
);

// File: tb/tb_blk_frame_rx.sv
module tb_blk_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_valid;
  logic [7:0] byte_in;
  logic       inv_order;
  logic       timeout;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       frm_valid, chk_err;
  logic [3:0] frm_src, frm_dst;
  logic [1:0] frm_type;
  logic [2:0] frm_ns, frm_nr;
  logic [7:0] frm_len;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [7:0] pay [256];
  logic [7:0] good_pay [256];
  logic [7:0] p_src, p_dst, p_type, p_ns, p_nr, p_len;

  always #10 clk = ~clk;

  blk_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .inv_order(inv_order), .timeout(timeout), .rd_addr(rd_addr), .rd_data(rd_data),
    .frm_valid(frm_valid), .chk_err(chk_err), .frm_src(frm_src), .frm_dst(frm_dst),
    .frm_type(frm_type), .frm_ns(frm_ns), .frm_nr(frm_nr), .frm_len(frm_len)
  );

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  // {type[1:0], ns[2:0], nr[2:0]}
  function automatic logic [7:0] exp_dec(input logic [7:0] c);
    if (c[4] == 1'b0 && c[0] == 1'b0) exp_dec = {2'd0, c[3:1], c[7:5]};
    else if (c[4:0] == 5'b01001)      exp_dec = {2'd1, 3'd0, c[7:5]};
    else if (c == 8'hEF)              exp_dec = {2'd2, 6'd0};
    else                              exp_dec = {2'd3, 6'd0};
  endfunction

  function automatic logic [7:0] garbage_byte(input logic [7:0] r);
    logic [7:0] g = r;
    if (g[7:4] == 4'd1) g[7:4] = 4'd2;
    if (g[3:0] == 4'd1) g[3:0] = 4'd0;
    return g;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_in    = inv_order ? rev8(b) : b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic pulse_timeout();
    timeout = 1'b1;
    @(negedge clk);
    timeout = 1'b0;
  endtask

  task automatic check_fields(input string req);
    check(req, "src",  frm_src,  p_src);
    check(req, "dst",  frm_dst,  p_dst);
    check(req, "type", frm_type, p_type);
    check(req, "ns",   frm_ns,   p_ns);
    check(req, "nr",   frm_nr,   p_nr);
    check(req, "len",  frm_len,  p_len);
  endtask

  task automatic check_buf(input string req);
    int errs = 0;
    for (int i = 0; i < p_len; i++) begin
      rd_addr = i[7:0];
      #1;
      if (rd_data !== good_pay[i]) begin
        if (errs == 0)
          $display("FAIL %s payload[%0d]: actual=0x%0h expected=0x%0h", req, i, rd_data, good_pay[i]);
        errs++;
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  // Sends a full block from pay[]; corrupt flips the check byte.
  task automatic run_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] l,
                           input bit corrupt, input string req);
    logic [7:0] x;
    logic [7:0] d;
    x = a ^ c ^ l;
    send_byte(a);
    send_byte(c);
    send_byte(l);
    for (int i = 0; i < l; i++) begin
      x = x ^ pay[i];
      send_byte(pay[i]);
    end
    send_byte(corrupt ? (x ^ 8'h5A) : x);
    if (!corrupt) begin
      check({req, "/R4"}, "frm_valid", frm_valid, 1);
      check({req, "/R4"}, "chk_err",   chk_err,   0);
      d = exp_dec(c);
      p_src = {4'd0, a[7:4]}; p_dst = {4'd0, a[3:0]};
      p_type = {6'd0, d[7:6]}; p_ns = {5'd0, d[5:3]}; p_nr = {5'd0, d[2:0]};
      p_len = l;
      for (int i = 0; i < 256; i++) good_pay[i] = (i < l) ? pay[i] : good_pay[i];
      check_fields({req, "/R2/R3/R6"});
      check_buf({req, "/R3"});
    end else begin
      check("R5", "chk_err",   chk_err,   1);
      check("R5", "frm_valid", frm_valid, 0);
      check_fields("R5 hold");
    end
    @(negedge clk);
    check("R4", "valid one cycle", frm_valid, 0);
    check("R5", "err one cycle",   chk_err,   0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, c, l;
    logic [31:0] r;
    int ng;
    r = $urandom(32'h5EED_1234);
    rst_n = 1'b0; byte_valid = 1'b0; byte_in = 8'h00; inv_order = 1'b0;
    timeout = 1'b0; rd_addr = 8'h00;
    p_src = 0; p_dst = 0; p_type = 0; p_ns = 0; p_nr = 0; p_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check("R12", "frm_valid", frm_valid, 0);
    check("R12", "chk_err", chk_err, 0);
    check_fields("R12");

    // R1: non-address bytes dropped, then good block; R6 info block
    send_byte(8'h22); send_byte(8'h00); send_byte(8'hFF);
    check("R1", "no strobe on garbage", frm_valid | chk_err, 0);
    for (int i = 0; i < 5; i++) pay[i] = 8'h30 + i[7:0];
    run_frame(8'h12, 8'hAC, 8'd5, 1'b0, "R1");

    // R13: garbage keeps fields and buffer
    send_byte(8'h44); send_byte(8'h20);
    check_fields("R13");
    check_buf("R13");

    // R1 low-nibble address; R7 reject
    pay[0] = 8'h99;
    run_frame(8'h31, 8'hA9, 8'd1, 1'b0, "R1/R7");
    // R8 reset code and unknown
    run_frame(8'h1F, 8'hEF, 8'd0, 1'b0, "R8");
    run_frame(8'h51, 8'h03, 8'd0, 1'b0, "R8/R11");

    // R5 bad check
    for (int i = 0; i < 3; i++) pay[i] = 8'hC0 ^ i[7:0];
    run_frame(8'h17, 8'h02, 8'd3, 1'b1, "R5");

    // R9 inverse order
    inv_order = 1'b1;
    for (int i = 0; i < 4; i++) pay[i] = 8'h81 + 8'(i * 3);
    run_frame(8'h13, 8'h4E, 8'd4, 1'b0, "R9");
    inv_order = 1'b0;

    // R10 timeout mid-block
    send_byte(8'h12); send_byte(8'h00); send_byte(8'd9);
    pulse_timeout();
    pulse_timeout();
    check("R10", "no strobe", frm_valid | chk_err, 0);
    pay[0] = 8'h11; pay[1] = 8'h22;
    run_frame(8'h21, 8'h62, 8'd2, 1'b0, "R10");

    // random blocks
    for (int n = 0; n < 60; n++) begin
      ng = $urandom_range(0, 2);
      for (int g = 0; g < ng; g++) send_byte(garbage_byte($urandom_range(0, 255)));
      a = $urandom_range(0, 255);
      if ($urandom_range(0, 1)) a[7:4] = 4'd1; else a[3:0] = 4'd1;
      c = ($urandom_range(0, 7) == 0) ? 8'hEF : 8'($urandom_range(0, 255));
      l = $urandom_range(0, 24);
      for (int i = 0; i < l; i++) pay[i] = $urandom_range(0, 255);
      inv_order = ($urandom_range(0, 3) == 0);
      run_frame(a, c, l, ($urandom_range(0, 4) == 0), "R3 random");
      inv_order = 1'b0;
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule